// File: doc/BRIEF.md
# Capability Register File with Bounds-Narrowing Derive

This block holds a small set of capability registers for a processor that controls memory access through capabilities. Each capability names a region (a base address and a length in bytes) and carries three permission bits: read, write and execute. Two combinational read ports serve operand fetch. One synchronous write port installs whole capabilities, as ordinary moves and loads do.

A second write path performs the derive operation. It takes a parent capability from a source register and three operand values from the general-purpose side: a base advance, a length reduction and a permission mask. It writes a child capability to a destination register. The child's base is the parent base plus the advance, its length is the parent length minus the reduction, and its permissions are the parent permissions ANDed with the mask. A derive that would reach outside the parent region is refused: a fault output goes high in the same cycle and the destination keeps its old contents. A derive can therefore shrink a region or drop rights, but never widen either.

Top module: `cap_regfile`

## Requirements
- R1: While reset is asserted and right after it, every register reads base 0, length 0 and permissions 3'b000.
- R2: With the write enable high at a clock edge, the addressed register afterwards holds the written base, length and permissions. Both read ports return any register's contents combinationally from its index.
- R3: A derive that is accepted writes the destination, in one clock edge, with base = parent base + advance (modulo 2^ADDR_W), length = parent length - reduction, and permissions = parent permissions AND mask.
- R4: The fault output is high, in the same cycle as the request, exactly when derive is enabled and NOT (advance <= reduction AND reduction <= parent length). With derive disabled it is low, whatever the operands.
- R5: A refused derive leaves the destination register unchanged.
- R6: Source and destination may be the same register. The result is computed from the contents before the edge.
- R7: If an accepted derive and the write port target the same register in the same cycle, the derive result is stored. If the derive is refused, or targets another register, the port write still takes effect.
- R8: An accepted derive never widens the parent. Child length + advance <= parent length, and the child holds no permission bit that the parent lacks. Permission bit 0 is read, bit 1 is write and bit 2 is execute.
- R9: A cycle with derive disabled changes no register except the one the write port addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | IDX_W | Read port A register index |
| rd_a_base_o | output | ADDR_W | Read port A base |
| rd_a_len_o | output | LEN_W | Read port A length |
| rd_a_perm_o | output | 3 | Read port A permissions {x,w,r} |
| rd_b_idx_i | input | IDX_W | Read port B register index |
| rd_b_base_o | output | ADDR_W | Read port B base |
| rd_b_len_o | output | LEN_W | Read port B length |
| rd_b_perm_o | output | 3 | Read port B permissions {x,w,r} |
| wr_en_i | input | 1 | Write port enable |
| wr_idx_i | input | IDX_W | Write port register index |
| wr_base_i | input | ADDR_W | Write port base |
| wr_len_i | input | LEN_W | Write port length |
| wr_perm_i | input | 3 | Write port permissions |
| dv_en_i | input | 1 | Derive request |
| dv_src_i | input | IDX_W | Derive parent register |
| dv_dst_i | input | IDX_W | Derive destination register |
| dv_adv_i | input | LEN_W | Base advance |
| dv_red_i | input | LEN_W | Length reduction |
| dv_mask_i | input | 3 | Permission mask |
| dv_fault_o | output | 1 | Derive refused (combinational) |

## Verification
The properties assume that the request inputs are stable and known around each rising edge. They also assume that stored regions satisfy base + length <= 2^ADDR_W, so an advance inside the parent never wraps the address. The bench changes every input only on falling edges. It also keeps every base it writes low enough that the stored region ends inside the address space. Within that envelope it sweeps parent lengths, advances and reductions across both sides of the two fault bounds.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned PERM_W = 3;
  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_WR = 1;
  localparam int unsigned PERM_X = 2;

  typedef logic [PERM_W-1:0] perm_t;

  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_PORT   = 2'd1,
    SRC_DERIVE = 2'd2
  } upd_src_e;

  function automatic perm_t perm_narrow(perm_t parent, perm_t mask);
    return parent & mask;
  endfunction
endpackage

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int unsigned N_CAPS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_CAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  perm_t             wr_perm_i,
  input  logic              dv_en_i,
  input  logic [IDX_W-1:0]  dv_idx_i,
  input  logic [ADDR_W-1:0] dv_base_i,
  input  logic [LEN_W-1:0]  dv_len_i,
  input  perm_t             dv_perm_i,
  output logic [ADDR_W-1:0] base_o [N_CAPS],
  output logic [LEN_W-1:0]  len_o  [N_CAPS],
  output perm_t             perm_o [N_CAPS]
);

  for (genvar i = 0; i < N_CAPS; i++) begin : g_ent
    upd_src_e          sel;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    perm_t             perm_q;

    // derive path has priority over the port on a collision
    always_comb begin
      sel = SRC_HOLD;
      if (dv_en_i && (dv_idx_i == IDX_W'(i)))      sel = SRC_DERIVE;
      else if (wr_en_i && (wr_idx_i == IDX_W'(i))) sel = SRC_PORT;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        len_q  <= '0;
        perm_q <= '0;
      end else begin
        unique case (sel)
          SRC_DERIVE: begin
            base_q <= dv_base_i;
            len_q  <= dv_len_i;
            perm_q <= dv_perm_i;
          end
          SRC_PORT: begin
            base_q <= wr_base_i;
            len_q  <= wr_len_i;
            perm_q <= wr_perm_i;
          end
          default: ;
        endcase
      end
    end

    assign base_o[i] = base_q;
    assign len_o[i]  = len_q;
    assign perm_o[i] = perm_q;
  end

endmodule

// File: rtl/cap_derive.sv
module cap_derive
  import cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] par_base_i,
  input  logic [LEN_W-1:0]  par_len_i,
  input  perm_t             par_perm_i,
  input  logic [LEN_W-1:0]  adv_i,
  input  logic [LEN_W-1:0]  red_i,
  input  perm_t             mask_i,
  output logic [ADDR_W-1:0] kid_base_o,
  output logic [LEN_W-1:0]  kid_len_o,
  output perm_t             kid_perm_o,
  output logic              commit_o,
  output logic              fault_o
);

  logic adv_ok, red_ok, legal;

  // advance <= reduction keeps the child end inside the parent end;
  // reduction <= length keeps the child length non-negative
  assign adv_ok = (adv_i <= red_i);
  assign red_ok = (red_i <= par_len_i);
  assign legal  = adv_ok & red_ok;

  assign kid_base_o = par_base_i + ADDR_W'(adv_i);
  assign kid_len_o  = par_len_i - red_i;
  assign kid_perm_o = perm_narrow(par_perm_i, mask_i);

  assign commit_o = en_i & legal;
  assign fault_o  = en_i & ~legal;

endmodule

// File: rtl/cap_rd_port.sv
module cap_rd_port
  import cap_pkg::*;
#(
  parameter int unsigned N_CAPS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_CAPS)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] base_i [N_CAPS],
  input  logic [LEN_W-1:0]  len_i  [N_CAPS],
  input  perm_t             perm_i [N_CAPS],
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  len_o,
  output perm_t             perm_o
);

  always_comb begin
    base_o = '0;
    len_o  = '0;
    perm_o = '0;
    for (int unsigned k = 0; k < N_CAPS; k++) begin
      if (idx_i == IDX_W'(k)) begin
        base_o = base_i[k];
        len_o  = len_i[k];
        perm_o = perm_i[k];
      end
    end
  end

endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
  import cap_pkg::*;
#(
  parameter int unsigned N_CAPS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_CAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [ADDR_W-1:0] rd_a_base_o,
  output logic [LEN_W-1:0]  rd_a_len_o,
  output logic [2:0]        rd_a_perm_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [ADDR_W-1:0] rd_b_base_o,
  output logic [LEN_W-1:0]  rd_b_len_o,
  output logic [2:0]        rd_b_perm_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [2:0]        wr_perm_i,
  input  logic              dv_en_i,
  input  logic [IDX_W-1:0]  dv_src_i,
  input  logic [IDX_W-1:0]  dv_dst_i,
  input  logic [LEN_W-1:0]  dv_adv_i,
  input  logic [LEN_W-1:0]  dv_red_i,
  input  logic [2:0]        dv_mask_i,
  output logic              dv_fault_o
);

  logic [ADDR_W-1:0] cap_base [N_CAPS];
  logic [LEN_W-1:0]  cap_len  [N_CAPS];
  perm_t             cap_perm [N_CAPS];

  logic [ADDR_W-1:0] par_base, kid_base;
  logic [LEN_W-1:0]  par_len, kid_len;
  perm_t             par_perm, kid_perm;
  logic              dv_commit;

  cap_store #(.N_CAPS(N_CAPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_base_i (wr_base_i),
    .wr_len_i  (wr_len_i),
    .wr_perm_i (wr_perm_i),
    .dv_en_i   (dv_commit),
    .dv_idx_i  (dv_dst_i),
    .dv_base_i (kid_base),
    .dv_len_i  (kid_len),
    .dv_perm_i (kid_perm),
    .base_o    (cap_base),
    .len_o     (cap_len),
    .perm_o    (cap_perm)
  );

  // parent fetch shares the read-port mux structure
  cap_rd_port #(.N_CAPS(N_CAPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_par (
    .idx_i (dv_src_i), .base_i(cap_base), .len_i(cap_len), .perm_i(cap_perm),
    .base_o(par_base), .len_o(par_len), .perm_o(par_perm)
  );

  cap_rd_port #(.N_CAPS(N_CAPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rd_a (
    .idx_i (rd_a_idx_i), .base_i(cap_base), .len_i(cap_len), .perm_i(cap_perm),
    .base_o(rd_a_base_o), .len_o(rd_a_len_o), .perm_o(rd_a_perm_o)
  );

  cap_rd_port #(.N_CAPS(N_CAPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rd_b (
    .idx_i (rd_b_idx_i), .base_i(cap_base), .len_i(cap_len), .perm_i(cap_perm),
    .base_o(rd_b_base_o), .len_o(rd_b_len_o), .perm_o(rd_b_perm_o)
  );

  cap_derive #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_derive (
    .en_i       (dv_en_i),
    .par_base_i (par_base),
    .par_len_i  (par_len),
    .par_perm_i (par_perm),
    .adv_i      (dv_adv_i),
    .red_i      (dv_red_i),
    .mask_i     (dv_mask_i),
    .kid_base_o (kid_base),
    .kid_len_o  (kid_len),
    .kid_perm_o (kid_perm),
    .commit_o   (dv_commit),
    .fault_o    (dv_fault_o)
  );

endmodule

// File: rtl/cap_regfile_chk.sv
module cap_regfile_chk #(
  parameter int unsigned N_CAPS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_CAPS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [ADDR_W-1:0] wr_base_i,
  input logic [LEN_W-1:0]  wr_len_i,
  input logic [2:0]        wr_perm_i,
  input logic              dv_en_i,
  input logic [IDX_W-1:0]  dv_src_i,
  input logic [IDX_W-1:0]  dv_dst_i,
  input logic [LEN_W-1:0]  dv_adv_i,
  input logic [LEN_W-1:0]  dv_red_i,
  input logic [2:0]        dv_mask_i,
  input logic              dv_fault_o,
  input logic [ADDR_W-1:0] cap_base [N_CAPS],
  input logic [LEN_W-1:0]  cap_len  [N_CAPS],
  input logic [2:0]        cap_perm [N_CAPS]
);

  logic dv_ok;
  assign dv_ok = dv_en_i && !dv_fault_o;

  for (genvar i = 0; i < N_CAPS; i++) begin : g_rst
    assert_reset_clear_R1: assert property (@(posedge clk_i)
      !rst_ni |-> (cap_len[i] == '0 && cap_perm[i] == '0 && cap_base[i] == '0));
  end

  assert_fault_rule_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_fault_o == (dv_en_i && !(dv_adv_i <= dv_red_i && dv_red_i <= cap_len[dv_src_i])));

  assert_port_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(dv_ok && dv_dst_i == wr_idx_i)) |=>
      (cap_base[$past(wr_idx_i)] == $past(wr_base_i) &&
       cap_len[$past(wr_idx_i)]  == $past(wr_len_i) &&
       cap_perm[$past(wr_idx_i)] == $past(wr_perm_i)));

  assert_derive_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_ok |=> cap_len[$past(dv_dst_i)] == $past(cap_len[dv_src_i] - dv_red_i));

  assert_refused_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_fault_o && !(wr_en_i && wr_idx_i == dv_dst_i)) |=>
      (cap_base[$past(dv_dst_i)] == $past(cap_base[dv_dst_i]) &&
       cap_len[$past(dv_dst_i)]  == $past(cap_len[dv_dst_i]) &&
       cap_perm[$past(dv_dst_i)] == $past(cap_perm[dv_dst_i])));

  assert_no_widen_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_ok |=> ({1'b0, cap_len[$past(dv_dst_i)]} + {1'b0, $past(dv_adv_i)})
              <= {1'b0, $past(cap_len[dv_src_i])});

  assert_no_widen_perm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_ok |=> (cap_perm[$past(dv_dst_i)] & ~$past(cap_perm[dv_src_i])) == 3'b000);

  assert_idle_fault_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_en_i |-> !dv_fault_o);

  for (genvar i = 0; i < N_CAPS; i++) begin : g_idle
    assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dv_en_i && !(wr_en_i && wr_idx_i == IDX_W'(i))) |=>
        ($stable(cap_base[i]) && $stable(cap_len[i]) && $stable(cap_perm[i])));
  end

endmodule

bind cap_regfile cap_regfile_chk #(.N_CAPS(N_CAPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_base_i  (wr_base_i),
  .wr_len_i   (wr_len_i),
  .wr_perm_i  (wr_perm_i),
  .dv_en_i    (dv_en_i),
  .dv_src_i   (dv_src_i),
  .dv_dst_i   (dv_dst_i),
  .dv_adv_i   (dv_adv_i),
  .dv_red_i   (dv_red_i),
  .dv_mask_i  (dv_mask_i),
  .dv_fault_o (dv_fault_o),
  .cap_base   (cap_base),
  .cap_len    (cap_len),
  .cap_perm   (cap_perm)
);

// File: tb/cap_regfile_bench.sv
`timescale 1ns/1ps
module cap_regfile_bench;
  localparam int unsigned N  = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned LW = 6;
  localparam int unsigned IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0;
  logic [AW-1:0] rd_a_base, rd_b_base;
  logic [LW-1:0] rd_a_len, rd_b_len;
  logic [2:0]    rd_a_perm, rd_b_perm;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_base = '0;
  logic [LW-1:0] wr_len = '0;
  logic [2:0]    wr_perm = '0;
  logic          dv_en = 1'b0;
  logic [IW-1:0] dv_src = '0, dv_dst = '0;
  logic [LW-1:0] dv_adv = '0, dv_red = '0;
  logic [2:0]    dv_mask = '0;
  logic          dv_fault;

  cap_regfile #(.N_CAPS(N), .ADDR_W(AW), .LEN_W(LW)) u_cap_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_base_o(rd_a_base), .rd_a_len_o(rd_a_len), .rd_a_perm_o(rd_a_perm),
    .rd_b_idx_i(rd_b_idx), .rd_b_base_o(rd_b_base), .rd_b_len_o(rd_b_len), .rd_b_perm_o(rd_b_perm),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_base_i(wr_base), .wr_len_i(wr_len), .wr_perm_i(wr_perm),
    .dv_en_i(dv_en), .dv_src_i(dv_src), .dv_dst_i(dv_dst), .dv_adv_i(dv_adv), .dv_red_i(dv_red),
    .dv_mask_i(dv_mask), .dv_fault_o(dv_fault)
  );

  int unsigned n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [AW-1:0] m_base [N];
  logic [LW-1:0] m_len  [N];
  logic [2:0]    m_perm [N];

  task automatic chk_reg(int unsigned i, string req);
    rd_a_idx = IW'(i);
    rd_b_idx = IW'(N - 1 - i);
    #0.2;
    n_vec++;
    if ({rd_a_base, rd_a_len, rd_a_perm} !== {m_base[i], m_len[i], m_perm[i]}) begin
      n_bad++;
      $display("FAIL %s portA reg%0d got b=%0d l=%0d p=%0d exp b=%0d l=%0d p=%0d", req, i,
               rd_a_base, rd_a_len, rd_a_perm, m_base[i], m_len[i], m_perm[i]);
    end
    n_vec++;
    if ({rd_b_base, rd_b_len, rd_b_perm} !== {m_base[N-1-i], m_len[N-1-i], m_perm[N-1-i]}) begin
      n_bad++;
      $display("FAIL %s portB reg%0d got b=%0d l=%0d p=%0d exp b=%0d l=%0d p=%0d", req, N-1-i,
               rd_b_base, rd_b_len, rd_b_perm, m_base[N-1-i], m_len[N-1-i], m_perm[N-1-i]);
    end
  endtask

  task automatic chk_all(string req);
    for (int unsigned i = 0; i < N; i++) chk_reg(i, req);
  endtask

  task automatic chk_fault(bit exp, string req);
    #0.5;
    n_vec++;
    if (dv_fault !== exp) begin
      n_bad++;
      $display("FAIL %s fault got %0b exp %0b (adv=%0d red=%0d)", req, dv_fault, exp, dv_adv, dv_red);
    end
  endtask

  // one cycle: optional port write and optional derive, model updated per requirements
  task automatic step(bit we, int unsigned wi, int unsigned wb, int unsigned wl, int unsigned wp,
                      bit de, int unsigned s, int unsigned d, int unsigned adv,
                      int unsigned red, int unsigned msk, string req);
    bit legal;
    logic [AW-1:0] nb; logic [LW-1:0] nl; logic [2:0] np;
    @(negedge clk);
    wr_en = we; wr_idx = IW'(wi); wr_base = AW'(wb); wr_len = LW'(wl); wr_perm = 3'(wp);
    dv_en = de; dv_src = IW'(s); dv_dst = IW'(d);
    dv_adv = LW'(adv); dv_red = LW'(red); dv_mask = 3'(msk);
    legal = (adv <= red) && (red <= int'(m_len[s]));
    nb = m_base[s] + AW'(adv);
    nl = LW'(int'(m_len[s]) - int'(red));
    np = m_perm[s] & 3'(msk);
    chk_fault(de && !legal, req);
    @(negedge clk);
    wr_en = 1'b0; dv_en = 1'b0;
    if (we) begin m_base[wi] = AW'(wb); m_len[wi] = LW'(wl); m_perm[wi] = 3'(wp); end
    if (de && legal) begin m_base[d] = nb; m_len[d] = nl; m_perm[d] = np; end
  endtask

  initial begin
    int lens [5] = '{0, 1, 7, 33, 63};
    int unsigned k = 0;
    for (int unsigned i = 0; i < N; i++) begin m_base[i] = '0; m_len[i] = '0; m_perm[i] = '0; end
    #1;
    chk_all("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1");

    // R2: fill every register through the port, read back on both ports
    for (int unsigned i = 0; i < N; i++)
      step(1, i, 16 * i + 3, 5 * i + 2, i, 0, 0, 0, 0, 0, 0, "R2");
    chk_all("R2");

    // R3 / R4 / R5 / R8: sweep parent length, reduction and advance across both bounds
    foreach (lens[li]) begin
      for (int red = 0; red <= lens[li] + 2 && red < 64; red++) begin
        for (int adv = 0; adv <= red + 1 && adv < 64; adv++) begin
          int unsigned s = k % N;
          int unsigned d = (3 * k + 1) % N;
          step(1, s, (k * 7) % 64, lens[li], k % 8, 0, 0, 0, 0, 0, 0, "R2");
          step(0, 0, 0, 0, 0, 1, s, d, adv, red, (k * 5 + 3) % 8,
               (adv <= red && red <= lens[li]) ? "R3" : "R5");
          chk_reg(d, (adv <= red && red <= lens[li]) ? "R3" : "R5");
          chk_reg(s, "R8");
          k++;
        end
      end
    end
    chk_all("R8");

    // R6: source equals destination
    step(1, 4, 100, 40, 7, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 4, 4, 10, 15, 5, "R6");
    chk_reg(4, "R6");
    step(0, 0, 0, 0, 0, 1, 4, 4, 25, 25, 7, "R6");
    chk_reg(4, "R6");
    step(0, 0, 0, 0, 0, 1, 4, 4, 0, 1, 6, "R6");
    chk_reg(4, "R6");

    // R7: port write and derive in the same cycle
    step(1, 2, 50, 30, 7, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 5, 9, 9, 1, 1, 2, 5, 4, 8, 3, "R7");
    chk_all("R7");
    step(1, 6, 11, 12, 2, 1, 2, 6, 9, 8, 7, "R7");
    chk_all("R7");
    step(1, 1, 77, 17, 4, 1, 2, 3, 1, 2, 7, "R7");
    chk_all("R7");

    // R4 / R9: derive disabled with operands that would fault
    step(0, 0, 0, 0, 0, 0, 2, 0, 50, 60, 0, "R4");
    chk_all("R9");
    step(1, 7, 1, 1, 1, 0, 3, 3, 63, 0, 0, "R9");
    chk_all("R9");

    // reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    for (int unsigned i = 0; i < N; i++) begin m_base[i] = '0; m_len[i] = '0; m_perm[i] = '0; end
    #0.5;
    chk_all("R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete got running exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule